// File: doc/BRIEF.md
# Infrared Run-Length Sampling Receiver

This block turns a raw infrared receiver line into a stream of compact code bytes. The line is first brought into the clock domain through a two-stage synchroniser. It is then sampled once for each pulse of a sample-tick strobe. Each stretch of ticks at one level becomes a single byte. The top bit of that byte is the level and the low seven bits are the run length minus one. A run that lasts 128 ticks is cut into a full-length code, and counting then starts again. An inversion control flips the level that gets recorded.

The codes go into a 16-entry receive queue. A CPU pulls entries out with a data-read strobe: the head of the queue is always visible on the data port, and the strobe removes it. A second strobe reads a status byte. That byte holds a live data-ready flag and two sticky flags, overrun and timeout, which clear when the status is read. Only one of the four sampling-mode encodings produces codes; the other three leave the sampler idle.

Top module: `irrl_rx`

## Requirements
- R1: The sampler produces codes only while `mode_sel` is 2'b00. With 2'b01, 2'b10 or 2'b11 no code is ever written, and a run in progress is abandoned.
- R2: A code is written on the tick where the sampled level differs from the current run. Bit 7 holds the run level (0 low, 1 high) and bits 6:0 hold the run length in ticks minus one. The first tick after reset or after idle starts a run and writes nothing.
- R3: On the tick where a run reaches 128 ticks, the code {level, 7'h7F} is written. The next tick starts a new run, at whatever level is then sampled.
- R4: With `inv_en` high, the recorded level is the complement of the line: a high line gives bit 7 = 0 and a low line gives bit 7 = 1.
- R5: The queue holds 16 codes in arrival order. `data_out` shows the oldest code, or 8'h00 when the queue is empty. A `data_rd` pulse removes that code. A code that arrives while 16 are stored is discarded, and the stored codes are kept.
- R6: `stat_out` is 8'h00 after reset, and bits 7:3 always read 0. Bit 0 is 1 exactly while the queue holds at least one code.
- R7: Status bit 1 (overrun) is set when a code is discarded because the queue is full. It is cleared by a `stat_rd` pulse.
- R8: Status bit 2 (timeout) is set on the 512th consecutive tick with a non-empty queue during which no code was written and no code was read. It is cleared by a `stat_rd` pulse.
- R9: When a `stat_rd` pulse and a new overrun or timeout event fall in the same cycle, the corresponding flag stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle sample strobe |
| ir_in | input | 1 | Asynchronous infrared line |
| mode_sel | input | 2 | Sampling mode; 2'b00 selects run-length coding |
| inv_en | input | 1 | Invert the recorded level |
| data_rd | input | 1 | Remove the head code from the queue |
| data_out | output | 8 | Head code of the queue, 8'h00 when empty |
| stat_rd | input | 1 | Status read; clears the sticky flags |
| stat_out | output | 8 | {5'b0, timeout, overrun, data ready} |

## Verification
The timeout is the hardest state to reach. While the sampler runs, it writes a code at least every 128 ticks, and each write restarts the 512-tick idle window. The stimulus therefore loads a single code and then switches `mode_sel` to an idle encoding while ticks keep arriving. It checks the status one tick before the limit and again on the limit itself. Overrun, and the case where a status read coincides with the event, are reached by toggling the line on every tick so that every tick writes a code. The status read is then placed on the seventeenth write.

// File: rtl/irrl_pkg.sv
package irrl_pkg;
  localparam int LEN_W = 7;
  localparam int CODE_W = LEN_W + 1;
  localparam logic [1:0] MODE_TPER = 2'b00;

  typedef logic [CODE_W-1:0] code_t;

  // level in the top bit, run length minus one below it
  function automatic code_t make_code(input logic lvl, input logic [LEN_W-1:0] len_m1);
    return {lvl, len_m1};
  endfunction

  // sticky flag: an event wins over a clear in the same cycle
  function automatic logic next_flag(input logic cur, input logic evt, input logic clr);
    return evt | (cur & ~clr);
  endfunction
endpackage

// File: rtl/irrl_sync.sv
module irrl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/irrl_runenc.sv
module irrl_runenc
  import irrl_pkg::*;
#(
  parameter int RUN_MAX = 128
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tick,
  input  logic  en,
  input  logic  lvl,
  output logic  push,
  output code_t code
);
  localparam int CW = $clog2(RUN_MAX);
  localparam logic [CW-1:0] CAP_M2 = CW'(RUN_MAX - 2);
  localparam logic [LEN_W-1:0] CAP_LEN = LEN_W'(RUN_MAX - 1);

  logic          active;
  logic          cur;
  logic [CW-1:0] cnt;
  logic          chg;
  logic          cap;

  assign chg  = tick && en && active && (lvl != cur);
  assign cap  = tick && en && active && !chg && (cnt == CAP_M2);
  assign push = chg || cap;
  assign code = cap ? make_code(cur, CAP_LEN) : make_code(cur, LEN_W'(cnt));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      cur    <= 1'b0;
      cnt    <= '0;
    end else if (!en) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (tick) begin
      if (!active) begin
        active <= 1'b1;
        cur    <= lvl;
        cnt    <= '0;
      end else if (chg) begin
        cur <= lvl;
        cnt <= '0;
      end else if (cap) begin
        active <= 1'b0;
        cnt    <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/irrl_fifo.sv
module irrl_fifo
  import irrl_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int FW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  code_t         din,
  input  logic          pop,
  output code_t         head,
  output logic          empty,
  output logic [FW-1:0] fill,
  output logic          wr,
  output logic          rd,
  output logic          ov_evt
);
  localparam logic [FW-1:0] FULL_V = FW'(DEPTH);

  code_t         mem [DEPTH];
  logic [AW-1:0] wp;
  logic [AW-1:0] rp;
  logic          full;

  assign empty  = (fill == '0);
  assign full   = (fill == FULL_V);
  assign rd     = pop && !empty;
  assign wr     = push && (!full || rd);
  assign ov_evt = push && !wr;
  assign head   = empty ? '0 : mem[rp];

  always_ff @(posedge clk) begin
    if (wr) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp   <= '0;
      rp   <= '0;
      fill <= '0;
    end else begin
      if (wr) wp <= wp + 1'b1;
      if (rd) rp <= rp + 1'b1;
      case ({wr, rd})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end
endmodule

// File: rtl/irrl_status.sv
module irrl_status
  import irrl_pkg::*;
#(
  parameter int TO_TICKS = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic empty,
  input  logic wr,
  input  logic rd,
  input  logic ov_evt,
  input  logic stat_rd,
  output logic to_evt,
  output logic to_flag,
  output logic ov_flag
);
  localparam int TW = $clog2(TO_TICKS + 1);
  localparam logic [TW-1:0] TO_LAST = TW'(TO_TICKS - 1);
  localparam logic [TW-1:0] TO_SAT  = TW'(TO_TICKS);

  logic [TW-1:0] tcnt;

  assign to_evt = tick && !empty && !wr && !rd && (tcnt == TO_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tcnt    <= '0;
      to_flag <= 1'b0;
      ov_flag <= 1'b0;
    end else begin
      if (empty || wr || rd)             tcnt <= '0;
      else if (tick && tcnt != TO_SAT)   tcnt <= tcnt + 1'b1;
      to_flag <= next_flag(to_flag, to_evt, stat_rd);
      ov_flag <= next_flag(ov_flag, ov_evt, stat_rd);
    end
  end
endmodule

// File: rtl/irrl_rx.sv
module irrl_rx
  import irrl_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int RUN_MAX    = 128,
  parameter int TO_RUNS    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       ir_in,
  input  logic [1:0] mode_sel,
  input  logic       inv_en,
  input  logic       data_rd,
  output logic [7:0] data_out,
  input  logic       stat_rd,
  output logic [7:0] stat_out
);
  localparam int TO_TICKS = TO_RUNS * RUN_MAX;
  localparam int FW = $clog2(FIFO_DEPTH) + 1;

  logic          line_q;
  logic          samp_lvl;
  logic          mode_ok;
  logic          enc_push;
  code_t         enc_code;
  code_t         head;
  logic          empty;
  logic [FW-1:0] fill;
  logic          q_wr;
  logic          q_rd;
  logic          ov_evt;
  logic          to_evt;
  logic          to_flag;
  logic          ov_flag;

  irrl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(ir_in), .q(line_q)
  );

  assign mode_ok  = (mode_sel == MODE_TPER);
  assign samp_lvl = line_q ^ inv_en;

  irrl_runenc #(.RUN_MAX(RUN_MAX)) u_enc (
    .clk(clk), .rst_n(rst_n), .tick(tick), .en(mode_ok), .lvl(samp_lvl),
    .push(enc_push), .code(enc_code)
  );

  irrl_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(enc_push), .din(enc_code), .pop(data_rd),
    .head(head), .empty(empty), .fill(fill), .wr(q_wr), .rd(q_rd), .ov_evt(ov_evt)
  );

  irrl_status #(.TO_TICKS(TO_TICKS)) u_stat (
    .clk(clk), .rst_n(rst_n), .tick(tick), .empty(empty), .wr(q_wr), .rd(q_rd),
    .ov_evt(ov_evt), .stat_rd(stat_rd), .to_evt(to_evt), .to_flag(to_flag),
    .ov_flag(ov_flag)
  );

  assign data_out = head;
  assign stat_out = {5'b00000, to_flag, ov_flag, ~empty};
endmodule

// File: rtl/irrl_chk.sv
module irrl_chk #(
  parameter int DEPTH = 16,
  localparam int FW = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic [1:0]    mode_sel,
  input logic          stat_rd,
  input logic [7:0]    stat_out,
  input logic          push,
  input logic          ov_evt,
  input logic          to_evt,
  input logic          empty,
  input logic [FW-1:0] fill
);
  localparam logic [FW-1:0] FULL_V = FW'(DEPTH);

  a_r6_high_zero: assert property (@(posedge clk) disable iff (!rst_n)
    stat_out[7:3] == 5'd0);

  a_r6_ready_set: assert property (@(posedge clk) disable iff (!rst_n)
    (fill != '0) |-> stat_out[0]);

  a_r1_idle_no_code: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel != 2'b00) |-> !push);

  a_r2_code_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> tick);

  a_r5_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= FULL_V);

  a_r5_full_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_evt && fill == FULL_V) |=> (fill == FULL_V));

  a_r7_ov_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ov_evt |=> stat_out[1]);

  a_r7_rd_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !ov_evt && !to_evt) |=> (stat_out[2:1] == 2'b00));

  a_r8_to_sets: assert property (@(posedge clk) disable iff (!rst_n)
    to_evt |=> stat_out[2]);

  a_r8_to_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    to_evt |-> !empty);

  a_r9_evt_beats_rd: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && ov_evt) |=> stat_out[1]);
endmodule

bind irrl_rx irrl_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .mode_sel(mode_sel), .stat_rd(stat_rd),
  .stat_out(stat_out), .push(enc_push), .ov_evt(ov_evt), .to_evt(to_evt),
  .empty(empty), .fill(fill)
);

// File: tb/irrl_rx_test.sv
`timescale 1ns/1ps
module irrl_rx_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       ir_in = 1'b0;
  logic [1:0] mode_sel = 2'b00;
  logic       inv_en = 1'b0;
  logic       data_rd = 1'b0;
  logic       stat_rd = 1'b0;
  logic [7:0] data_out;
  logic [7:0] stat_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irrl_rx uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ir_in(ir_in), .mode_sel(mode_sel),
    .inv_en(inv_en), .data_rd(data_rd), .data_out(data_out), .stat_rd(stat_rd),
    .stat_out(stat_out)
  );

  // {line level, ticks in run, expected code}
  localparam int NV = 7;
  localparam logic [16:0] VEC [NV] = '{
    {1'b1, 8'd3,   8'h82},
    {1'b0, 8'd1,   8'h00},
    {1'b1, 8'd128, 8'hFF},
    {1'b0, 8'd5,   8'h04},
    {1'b1, 8'd2,   8'h81},
    {1'b0, 8'd127, 8'h7E},
    {1'b1, 8'd1,   8'h80}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; tick = 1'b0; ir_in = 1'b0; mode_sel = 2'b00;
    inv_en = 1'b0; data_rd = 1'b0; stat_rd = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // drive the line, let it cross the synchroniser, then one tick
  task automatic tick_once(input logic lvl, input logic with_rd);
    ir_in = lvl;
    repeat (2) @(negedge clk);
    tick = 1'b1; stat_rd = with_rd;
    @(negedge clk);
    tick = 1'b0; stat_rd = 1'b0;
  endtask

  task automatic pop_chk(input string req, input logic [7:0] exp);
    chk(req, data_out, exp);
    data_rd = 1'b1;
    @(negedge clk);
    data_rd = 1'b0;
  endtask

  task automatic read_stat();
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
  endtask

  initial begin
    do_reset();
    chk("R6 reset status", stat_out, 8'h00);
    chk("R5 empty head", data_out, 8'h00);

    // vector table: runs of varied length, all in mode 00, no inversion
    for (int v = 0; v < NV; v++) begin
      for (int t = 0; t < int'(VEC[v][15:8]); t++) tick_once(VEC[v][16], 1'b0);
    end
    tick_once(1'b0, 1'b0);
    chk("R6 ready set", stat_out, 8'h01);
    for (int v = 0; v < NV; v++) begin
      pop_chk((VEC[v][15:8] == 8'd128) ? "R3 capped run" : "R2 run code", VEC[v][7:0]);
    end
    chk("R6 ready clears when empty", stat_out, 8'h00);

    // R1: non-coding modes write nothing
    for (int m = 1; m < 4; m++) begin
      do_reset();
      mode_sel = 2'(m);
      for (int t = 0; t < 12; t++) tick_once(t[0], 1'b0);
      chk("R1 idle mode status", stat_out, 8'h00);
      chk("R1 idle mode head", data_out, 8'h00);
    end

    // R3: 256-tick run gives two capped codes
    do_reset();
    for (int t = 0; t < 256; t++) tick_once(1'b0, 1'b0);
    pop_chk("R3 first cap", 8'h7F);
    pop_chk("R3 second cap", 8'h7F);
    chk("R3 no extra code", stat_out, 8'h00);

    // R4: inversion
    do_reset();
    inv_en = 1'b1;
    for (int t = 0; t < 4; t++) tick_once(1'b1, 1'b0);
    for (int t = 0; t < 2; t++) tick_once(1'b0, 1'b0);
    tick_once(1'b1, 1'b0);
    pop_chk("R4 inverted high", 8'h03);
    pop_chk("R4 inverted low", 8'h81);

    // R5/R7/R9: overrun
    do_reset();
    for (int t = 0; t < 3; t++) tick_once(1'b1, 1'b0);
    for (int i = 0; i < 16; i++) tick_once(i[0], 1'b0);
    chk("R5 full no overrun yet", stat_out, 8'h01);
    tick_once(1'b0, 1'b1);
    chk("R9 read with overrun keeps flag", stat_out, 8'h03);
    read_stat();
    chk("R7 overrun cleared", stat_out, 8'h01);
    tick_once(1'b1, 1'b0);
    chk("R7 overrun set", stat_out, 8'h03);
    read_stat();
    chk("R7 overrun cleared again", stat_out, 8'h01);
    pop_chk("R5 oldest kept", 8'h82);
    for (int k = 1; k < 16; k++) pop_chk("R5 stored code", k[0] ? 8'h00 : 8'h80);
    chk("R5 exactly 16 kept", stat_out, 8'h00);

    // R8: timeout with sampler idle
    do_reset();
    for (int t = 0; t < 2; t++) tick_once(1'b1, 1'b0);
    tick_once(1'b0, 1'b0);
    mode_sel = 2'b01;
    for (int t = 0; t < 511; t++) tick_once(1'b0, 1'b0);
    chk("R8 no timeout at 511", stat_out, 8'h01);
    tick_once(1'b0, 1'b0);
    chk("R8 timeout at 512", stat_out, 8'h05);
    read_stat();
    chk("R8 timeout cleared", stat_out, 8'h01);
    pop_chk("R8 code intact", 8'h81);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule